// File: doc/BRIEF.md
# Counted Loop Closing Unit with Condition Exit

This block performs the closing step of a counted loop that can be left in two ways. On a start strobe it samples a loop register, a 4-bit condition selector and the current status flags. If the selected condition holds, the loop ends at once: the register is left alone and no branch is taken. Otherwise the low part of the register is decremented and written back. The branch back to the top of the loop is taken unless the decrement wrapped the count to all ones, which is the second way out.

All results are registered and appear one clock after the strobe, together with a one-cycle done pulse. Two status outputs tell which exit, if any, was taken. Target address arithmetic and flag generation lie outside the block. The loop register is `REG_W` bits wide; only its low `CNT_W` bits count.

Top module: `dbl_loop_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, all strobe outputs (`done`, `reg_we`, `branch_taken`, `exit_on_cond`, `exit_on_count`) and `reg_out` are cleared to zero.
- R2: `done` is high for exactly the cycle after each cycle in which `start` was high. `reg_we`, `branch_taken`, `exit_on_cond` and `exit_on_count` are zero whenever `done` is low.
- R3: `flags` bits are [3] negative, [2] zero, [1] overflow, [0] carry. The codes of `cond_sel` from 0 to 15 mean: always, never, higher (!C&!Z), lower-or-same (C|Z), carry clear, carry set, not equal (!Z), equal (Z), overflow clear, overflow set, plus (!N), minus (N), signed ge (N==V), signed lt (N!=V), signed gt (!Z&(N==V)), signed le (Z|(N!=V)).
- R4: When the selected condition holds, the result has `exit_on_cond`=1, `reg_we`=0, `branch_taken`=0, and `reg_out` equals the sampled `loop_reg`.
- R5: When the selected condition does not hold, the result has `reg_we`=1 and `reg_out` low `CNT_W` bits equal to the sampled low bits minus one, modulo 2^`CNT_W`.
- R6: When the condition does not hold and the decremented count is not all ones, `branch_taken`=1 and both exit outputs are 0.
- R7: When the condition does not hold and the decremented count is all ones (sampled low bits were zero), `exit_on_count`=1, `branch_taken`=0, and `reg_out` low bits are all ones with `reg_we`=1.
- R8: The bits of `loop_reg` above `CNT_W` reach `reg_out` unchanged in every result.
- R9: The condition exit takes priority: with the condition true and a zero count, the result is a condition exit with no write and `exit_on_count`=0.
- R10: Starts on consecutive cycles each yield their own result on consecutive cycles, computed from the inputs sampled with that start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Perform one loop-closing step on the sampled inputs |
| loop_reg | input | REG_W | Current loop register value |
| cond_sel | input | 4 | Exit condition selector |
| flags | input | 4 | Status flags N, Z, V, C |
| reg_out | output | REG_W | Updated loop register value |
| reg_we | output | 1 | Write-back enable for the loop register |
| branch_taken | output | 1 | Branch back to the loop top |
| done | output | 1 | Result valid pulse |
| exit_on_cond | output | 1 | Loop left because the condition held |
| exit_on_count | output | 1 | Loop left because the count expired |

## Verification
The two exits can both be due in one step: a condition that holds while the count is zero, so the decrement would also wrap. The bench drives a true condition with a zero count under several codes and expects a condition exit with no write, the register unchanged and no count exit flagged. It also sweeps every code against every flag pattern with a nonzero count, so each condition is judged against a reference computed from the flag meanings alone.

// File: rtl/dbl_pkg.sv
package dbl_pkg;

  localparam int CC_W   = 4;
  localparam int FLAG_W = 4;
  localparam int CC_NUM = 1 << CC_W;

  typedef enum logic [CC_W-1:0] {
    CC_ALWAYS    = 4'd0,
    CC_NEVER     = 4'd1,
    CC_ABOVE     = 4'd2,
    CC_BELOW_EQ  = 4'd3,
    CC_NO_CARRY  = 4'd4,
    CC_CARRY     = 4'd5,
    CC_NOT_ZERO  = 4'd6,
    CC_ZERO      = 4'd7,
    CC_NO_OVF    = 4'd8,
    CC_OVF       = 4'd9,
    CC_POSITIVE  = 4'd10,
    CC_NEGATIVE  = 4'd11,
    CC_SIGNED_GE = 4'd12,
    CC_SIGNED_LT = 4'd13,
    CC_SIGNED_GT = 4'd14,
    CC_SIGNED_LE = 4'd15
  } cc_code_e;

  typedef struct packed {
    logic neg;
    logic zero;
    logic ovf;
    logic carry;
  } flags_t;

  typedef enum logic [1:0] {
    OUT_BRANCH    = 2'd0,
    OUT_EXIT_COND = 2'd1,
    OUT_EXIT_CNT  = 2'd2
  } step_kind_e;

endpackage

// File: rtl/dbl_cond_eval.sv
module dbl_cond_eval
  import dbl_pkg::*;
(
  input  logic [CC_W-1:0] code,
  input  flags_t          fl,
  output logic            hit
);

  localparam int PAIRS = CC_NUM / 2;

  // Each pair of codes: odd code tests a base term, even code its complement.
  logic [PAIRS-1:0]  base_term;
  logic [CC_NUM-1:0] cc_vec;
  logic              sgn_mismatch;

  assign sgn_mismatch = fl.neg ^ fl.ovf;

  always_comb begin
    base_term[0] = 1'b0;
    base_term[1] = fl.carry | fl.zero;
    base_term[2] = fl.carry;
    base_term[3] = fl.zero;
    base_term[4] = fl.ovf;
    base_term[5] = fl.neg;
    base_term[6] = sgn_mismatch;
    base_term[7] = fl.zero | sgn_mismatch;
  end

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    assign cc_vec[2*p]   = ~base_term[p];
    assign cc_vec[2*p+1] =  base_term[p];
  end

  assign hit = cc_vec[code];

endmodule

// File: rtl/dbl_count_step.sv
module dbl_count_step #(
  parameter int REG_W = 32,
  parameter int CNT_W = 16
) (
  input  logic [REG_W-1:0] cur,
  output logic [REG_W-1:0] nxt,
  output logic             expired
);

  logic [CNT_W-1:0] low_dec;

  assign low_dec = cur[CNT_W-1:0] - {{(CNT_W-1){1'b0}}, 1'b1};
  assign expired = &low_dec;

  if (REG_W > CNT_W) begin : g_upper
    assign nxt = {cur[REG_W-1:CNT_W], low_dec};
  end else begin : g_flat
    assign nxt = low_dec;
  end

endmodule

// File: rtl/dbl_result_reg.sv
module dbl_result_reg
  import dbl_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cond_hit,
  input  logic             expired,
  input  logic [REG_W-1:0] cur_val,
  input  logic [REG_W-1:0] dec_val,
  output logic [REG_W-1:0] q_val,
  output logic             q_we,
  output logic             q_taken,
  output logic             q_done,
  output logic             q_exit_cond,
  output logic             q_exit_cnt
);

  step_kind_e kind;

  always_comb begin
    if (cond_hit)      kind = OUT_EXIT_COND;
    else if (expired)  kind = OUT_EXIT_CNT;
    else               kind = OUT_BRANCH;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_val       <= '0;
      q_we        <= 1'b0;
      q_taken     <= 1'b0;
      q_done      <= 1'b0;
      q_exit_cond <= 1'b0;
      q_exit_cnt  <= 1'b0;
    end else begin
      q_done      <= start;
      q_we        <= 1'b0;
      q_taken     <= 1'b0;
      q_exit_cond <= 1'b0;
      q_exit_cnt  <= 1'b0;
      if (start) begin
        case (kind)
          OUT_EXIT_COND: begin
            q_val       <= cur_val;
            q_exit_cond <= 1'b1;
          end
          OUT_EXIT_CNT: begin
            q_val      <= dec_val;
            q_we       <= 1'b1;
            q_exit_cnt <= 1'b1;
          end
          default: begin
            q_val   <= dec_val;
            q_we    <= 1'b1;
            q_taken <= 1'b1;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/dbl_loop_ctrl.sv
module dbl_loop_ctrl
  import dbl_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [REG_W-1:0] loop_reg,
  input  logic [3:0]       cond_sel,
  input  logic [3:0]       flags,
  output logic [REG_W-1:0] reg_out,
  output logic             reg_we,
  output logic             branch_taken,
  output logic             done,
  output logic             exit_on_cond,
  output logic             exit_on_count
);

  logic             cond_hit;
  logic             cnt_expired;
  logic [REG_W-1:0] dec_val;
  flags_t           fl;

  assign fl = flags_t'(flags);

  dbl_cond_eval u_cond (
    .code (cond_sel),
    .fl   (fl),
    .hit  (cond_hit)
  );

  dbl_count_step #(.REG_W(REG_W), .CNT_W(CNT_W)) u_step (
    .cur     (loop_reg),
    .nxt     (dec_val),
    .expired (cnt_expired)
  );

  dbl_result_reg #(.REG_W(REG_W)) u_res (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .cond_hit    (cond_hit),
    .expired     (cnt_expired),
    .cur_val     (loop_reg),
    .dec_val     (dec_val),
    .q_val       (reg_out),
    .q_we        (reg_we),
    .q_taken     (branch_taken),
    .q_done      (done),
    .q_exit_cond (exit_on_cond),
    .q_exit_cnt  (exit_on_count)
  );

endmodule

// File: rtl/dbl_loop_ctrl_checker.sv
module dbl_loop_ctrl_checker #(
  parameter int REG_W = 32,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [REG_W-1:0] loop_reg,
  input logic [REG_W-1:0] reg_out,
  input logic             reg_we,
  input logic             branch_taken,
  input logic             done,
  input logic             exit_on_cond,
  input logic             exit_on_count
);

  logic             seen;
  logic [REG_W-1:0] prev_reg;
  logic [CNT_W-1:0] prev_low_dec;

  always_ff @(posedge clk) begin
    if (rst) seen <= 1'b0;
    else     seen <= 1'b1;
    prev_reg <= loop_reg;
  end

  assign prev_low_dec = prev_reg[CNT_W-1:0] - {{(CNT_W-1){1'b0}}, 1'b1};

  // R2: done follows start by one cycle
  p_done_follows_start_r2: assert property (@(posedge clk) disable iff (rst || !seen)
    done == $past(start));

  // R2: no strobe without done
  p_quiet_when_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !done |-> !(reg_we || branch_taken || exit_on_cond || exit_on_count));

  // R4, R6, R7: exactly one outcome per result
  p_one_outcome_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> $countones({branch_taken, exit_on_cond, exit_on_count}) == 1);

  // R4: condition exit never writes and keeps the value
  p_cond_exit_hold_r4: assert property (@(posedge clk) disable iff (rst || !seen)
    exit_on_cond |-> (!reg_we && reg_out == prev_reg));

  // R5: written value is the decremented low part
  p_write_is_decrement_r5: assert property (@(posedge clk) disable iff (rst || !seen)
    reg_we |-> reg_out[CNT_W-1:0] == prev_low_dec);

  // R7: count exit means wrapped to all ones
  p_count_exit_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    exit_on_count |-> (reg_we && (&reg_out[CNT_W-1:0])));

  // R6: a taken branch never carries the all-ones count
  p_taken_not_wrapped_r6: assert property (@(posedge clk) disable iff (rst)
    branch_taken |-> (reg_we && !(&reg_out[CNT_W-1:0])));

  // R8: upper bits pass through
  if (REG_W > CNT_W) begin : g_upper_chk
    p_upper_kept_r8: assert property (@(posedge clk) disable iff (rst || !seen)
      done |-> reg_out[REG_W-1:CNT_W] == prev_reg[REG_W-1:CNT_W]);
  end

endmodule

bind dbl_loop_ctrl dbl_loop_ctrl_checker #(.REG_W(REG_W), .CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .start         (start),
  .loop_reg      (loop_reg),
  .reg_out       (reg_out),
  .reg_we        (reg_we),
  .branch_taken  (branch_taken),
  .done          (done),
  .exit_on_cond  (exit_on_cond),
  .exit_on_count (exit_on_count)
);

// File: tb/dbl_loop_ctrl_test.sv
module dbl_loop_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int REG_W = 32;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [REG_W-1:0] loop_reg = '0;
  logic [3:0]       cond_sel = '0;
  logic [3:0]       flags = '0;
  logic [REG_W-1:0] reg_out;
  logic             reg_we, branch_taken, done, exit_on_cond, exit_on_count;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbl_loop_ctrl #(.REG_W(REG_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .start(start), .loop_reg(loop_reg),
    .cond_sel(cond_sel), .flags(flags), .reg_out(reg_out), .reg_we(reg_we),
    .branch_taken(branch_taken), .done(done), .exit_on_cond(exit_on_cond),
    .exit_on_count(exit_on_count)
  );

  task automatic check(input string req, input logic [REG_W-1:0] act,
                       input logic [REG_W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Reference from the condition meanings: N=bit3 Z=bit2 V=bit1 C=bit0
  function automatic logic cond_ref(input logic [3:0] c, input logic [3:0] f);
    logic n, z, v, cy;
    n = f[3]; z = f[2]; v = f[1]; cy = f[0];
    case (c)
      4'd0:  return 1'b1;
      4'd1:  return 1'b0;
      4'd2:  return !cy && !z;
      4'd3:  return cy || z;
      4'd4:  return !cy;
      4'd5:  return cy;
      4'd6:  return !z;
      4'd7:  return z;
      4'd8:  return !v;
      4'd9:  return v;
      4'd10: return !n;
      4'd11: return n;
      4'd12: return n == v;
      4'd13: return n != v;
      4'd14: return !z && (n == v);
      default: return z || (n != v);
    endcase
  endfunction

  // Compare all outputs to expectations for one step with the given inputs
  task automatic expect_result(input string req, input logic [REG_W-1:0] r,
                               input logic [3:0] c, input logic [3:0] f);
    logic hit;
    logic [CNT_W-1:0] low;
    logic [REG_W-1:0] exp_val;
    hit = cond_ref(c, f);
    low = r[CNT_W-1:0] - 1'b1;
    exp_val = hit ? r : {r[REG_W-1:CNT_W], low};
    check({req, " done"}, REG_W'(done), 1);
    check({req, " reg_out"}, reg_out, exp_val);
    check({req, " reg_we"}, REG_W'(reg_we), REG_W'(!hit));
    check({req, " exit_on_cond"}, REG_W'(exit_on_cond), REG_W'(hit));
    check({req, " exit_on_count"}, REG_W'(exit_on_count), REG_W'(!hit && (&low)));
    check({req, " branch_taken"}, REG_W'(branch_taken), REG_W'(!hit && !(&low)));
  endtask

  task automatic step(input string req, input logic [REG_W-1:0] r,
                      input logic [3:0] c, input logic [3:0] f);
    @(negedge clk);
    start = 1'b1; loop_reg = r; cond_sel = c; flags = f;
    @(negedge clk);
    start = 1'b0;
    expect_result(req, r, c, f);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reg_out", reg_out, 0);
    check("R1 strobes", REG_W'({done, reg_we, branch_taken, exit_on_cond, exit_on_count}), 0);
    rst = 1'b0;
  endtask

  task automatic t_all_conditions;
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 16; f++)
        step("R3", 32'h0000_0005, 4'(c), 4'(f));
  endtask

  task automatic t_decrement;
    step("R5 R6 count 1", 32'h1234_0001, 4'd1, 4'h0);
    step("R6 count max", 32'h0000_FFFF, 4'd1, 4'h0);
    step("R7 count zero", 32'h0000_0000, 4'd1, 4'h0);
    step("R8 upper kept", 32'hABCD_0000, 4'd6, 4'h4);
    step("R4 upper kept", 32'hABCD_0000, 4'd7, 4'h4);
  endtask

  task automatic t_priority;
    step("R9 always", 32'h5A5A_0000, 4'd0, 4'h0);
    step("R9 equal", 32'h0000_0000, 4'd7, 4'h4);
    step("R9 signed lt", 32'h0001_0000, 4'd13, 4'h8);
  endtask

  task automatic t_done_width;
    step("R2 pulse", 32'h0000_0010, 4'd1, 4'h0);
    @(negedge clk);
    check("R2 done low", REG_W'(done), 0);
    check("R2 strobes low", REG_W'({reg_we, branch_taken, exit_on_cond, exit_on_count}), 0);
    check("R2 value held", reg_out, 32'h0000_000F);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    start = 1'b1; loop_reg = 32'h0000_0003; cond_sel = 4'd1; flags = 4'h0;
    @(negedge clk);
    expect_result("R10 first", 32'h0000_0003, 4'd1, 4'h0);
    loop_reg = 32'h0000_0000; cond_sel = 4'd4; flags = 4'h1;
    @(negedge clk);
    expect_result("R10 second", 32'h0000_0000, 4'd4, 4'h1);
    loop_reg = 32'h7777_0002; cond_sel = 4'd11; flags = 4'h8;
    @(negedge clk);
    start = 1'b0;
    expect_result("R10 third", 32'h7777_0002, 4'd11, 4'h8);
  endtask

  initial begin
    t_reset();
    t_all_conditions();
    t_decrement();
    t_priority();
    t_done_width();
    t_back_to_back();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule